// File: doc/BRIEF.md
# Set-Associative Cache Controller with Selectable Write and Replacement Policies

The block is a small set-associative cache placed between a processor-side load/store port and a word-wide memory port. Each processor address is divided into three fields: a byte offset inside the line (low bits), a set index, and a tag made of the remaining upper bits. Each set holds `WAYS` lines. Each line carries a valid flag, a dirty flag and a stored tag. The tags of all ways of the indexed set are compared in the same cycle.

Three configuration inputs select the behaviour. `cfg_wback` picks write-back (1) or write-through (0) handling of write hits. `cfg_walloc` picks write-allocate (1) or write-around (0) handling of write misses. `cfg_repl` picks the victim rule: 0 = least recently used, 1 = oldest fill first, 2 = pseudo-random from a free-running LFSR (3 behaves as 0). When a set still has an empty way, that way is filled first under every rule. Line transfers to and from memory are bursts of `LINE_WORDS` single-word beats. Each beat uses its own valid/ready handshake.

The controller is a six-state machine. The states are IDLE, LOOKUP, WBACK, FILL, WTHRU and RESP. IDLE→LOOKUP happens when a request is accepted. From LOOKUP the machine goes to RESP on a read hit or a write-back write hit. It goes to WTHRU on a write-through write hit or a write-around write miss. On an allocating miss it goes to WBACK if the victim is dirty and to FILL otherwise. WBACK→FILL happens after the last beat of the writeback. FILL→LOOKUP happens after the last fill beat, and the lookup is then repeated and hits. WTHRU→RESP happens once the single write beat is accepted. RESP→IDLE always follows one cycle later.

Top module: `cache_ctrl`

## Requirements
- R1: With the default parameters (12-bit byte address, 32-bit words, 4 words per line, 4 sets, 2 ways), bits [1:0] select the byte, bits [3:2] the word, bits [5:4] the set and bits [11:6] the tag. Every line transfer starts at the line base, meaning word bits zero.
- R2: A read to a resident line completes without memory traffic, with `cpu_done` high in the second cycle after acceptance. A read to a non-resident line fetches the whole line first.
- R3: A read returns the value most recently written to that address through the processor port. If the address was never written, it returns the memory's contents.
- R4: `lookup_err` is asserted during LOOKUP when more than one valid way matches the tag. A hit needs exactly one match. Correct operation never creates a duplicate tag, so the flag stays low.
- R5: With `cfg_wback`=1, a write hit updates only the cache and marks the line dirty. A dirty victim is written back to memory as a full line before the new line is fetched.
- R6: With `cfg_wback`=0, every write is sent to memory as one write beat carrying the written word.
- R7: On a write miss with `cfg_walloc`=1 the line is fetched and then written. With `cfg_walloc`=0 one write beat goes to memory, nothing is fetched, and a later read of that line misses.
- R8: With `cfg_repl`=0 the victim is the least recently accessed way of the set. Hits count as accesses.
- R9: With `cfg_repl`=1 the victim is the way filled longest ago. Hits do not change the order.
- R10: With `cfg_repl`=2 the victim comes from an 8-bit free-running LFSR, and data correctness (R3) still holds.
- R11: A set with an invalid way fills that way and causes no writeback.
- R12: A burst has exactly `LINE_WORDS` beats at ascending word addresses. A beat holds its address and direction until `mem_ready` is high.
- R13: `cpu_ready` is high only in IDLE, so it is low during every memory transfer. `cpu_done` is a one-cycle pulse.
- R14: After reset, `cpu_ready`=1, `cpu_done`=0, `mem_valid`=0 and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wback | input | 1 | 1 = write-back, 0 = write-through on write hits |
| cfg_walloc | input | 1 | 1 = allocate, 0 = write-around on write misses |
| cfg_repl | input | 2 | Victim rule: 0 LRU, 1 fill order, 2 random |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted when high with `cpu_req` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` on reads |
| mem_valid | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | DATA_W | Write beat data |
| mem_ready | input | 1 | Memory accepts the beat; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Read beat data |
| lookup_err | output | 1 | Multiple-way tag match detected |

## Verification
Wrong bookkeeping in this cache does not show up when it happens. A stale recency age, a wrong fill pointer or a lost dirty flag shows up only at the next miss in that set. It appears there as a writeback that is missing or extra, or as a later access taking miss latency where a hit was expected, or the reverse. Corrupted line data shows up at the next read of that word as a wrong `cpu_rdata`. A dropped writeback shows up as wrong data only after the line has been evicted and fetched again. The bench therefore uses access latency, beat counts and beat addresses to detect hits and evictions, and it compares every read against a reference image of processor writes.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } cstate_t;

    typedef enum logic [1:0] {
        RP_LRU  = 2'd0,
        RP_FIFO = 2'd1,
        RP_RAND = 2'd2
    } repl_t;
endpackage

// File: rtl/cache_tag_match.sv
`timescale 1ns/1ps
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic                       multi,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;
    logic [WAY_W:0]  n_match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = set_valid[w] && (set_tags[w] == req_tag);
        end
    endgenerate

    always_comb begin
        n_match = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            n_match = n_match + {{WAY_W{1'b0}}, match[w]};
            if (match[w]) hit_way = WAY_W'(w);
        end
        hit   = (n_match == (WAY_W+1)'(1));
        multi = (n_match > (WAY_W+1)'(1));
    end
endmodule

// File: rtl/cache_victim.sv
`timescale 1ns/1ps
module cache_victim
    import cache_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int RND_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  repl_t            policy,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [RND_W-1:0] rnd_q;
    logic [WAY_W-1:0] inv_way, old_way;

    always_comb begin
        inv_way = '0;
        old_way = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (!set_valid[w]) inv_way = WAY_W'(w);
            if (age_q[sel_idx][w] == WAY_W'(WAYS-1)) old_way = WAY_W'(w);
        end
        if (!(&set_valid)) begin
            victim = inv_way;
        end else begin
            unique case (policy)
                RP_FIFO: victim = ptr_q[sel_idx];
                RP_RAND: victim = rnd_q[WAY_W-1:0];
                default: victim = old_way;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q <= RND_W'(1);
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            rnd_q <= {rnd_q[RND_W-2:0], rnd_q[7] ^ rnd_q[5] ^ rnd_q[4] ^ rnd_q[3]};
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[sel_idx][w] <= '0;
                    else if (age_q[sel_idx][w] < age_q[sel_idx][touch_way])
                        age_q[sel_idx][w] <= age_q[sel_idx][w] + WAY_W'(1);
                end
            end
            if (fill_en) ptr_q[sel_idx] <= fill_way + WAY_W'(1);
        end
    end

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_chk
            logic [WAYS-1:0] oldest;
            always_comb
                for (int w = 0; w < WAYS; w++)
                    oldest[w] = (age_q[s][w] == WAY_W'(WAYS-1));
            // R8: recency ages always form an order with one oldest way
            a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(oldest));
        end
    endgenerate
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4,
    parameter int WAYS       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wback,
    input  logic              cfg_walloc,
    input  logic [1:0]        cfg_repl,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              lookup_err
);
    localparam int BYTE_W = $clog2(DATA_W/8);
    localparam int WO_W   = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W - WO_W - BYTE_W;

    // line storage
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];

    // captured request
    cstate_t           state_q, state_d;
    logic              rq_we;
    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [WO_W-1:0]   rq_word;
    logic [DATA_W-1:0] rq_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic [WAY_W-1:0]  vic_q;
    logic [WO_W-1:0]   beat_q;

    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic              hit, multi;
    logic [WAY_W-1:0]  hit_way, victim;
    logic              beat_go, last_beat, touch_en, fill_en;
    logic              unused_byte;

    assign unused_byte = ^cpu_addr[BYTE_W-1:0];

    always_comb
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[rq_idx][w];

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tags (set_tags),
        .set_valid(valid_q[rq_idx]),
        .req_tag  (rq_tag),
        .hit      (hit),
        .multi    (multi),
        .hit_way  (hit_way)
    );

    cache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .policy   (repl_t'(cfg_repl)),
        .sel_idx  (rq_idx),
        .set_valid(valid_q[rq_idx]),
        .touch_en (touch_en),
        .touch_way(hit_way),
        .fill_en  (fill_en),
        .fill_way (vic_q),
        .victim   (victim)
    );

    assign beat_go   = mem_valid && mem_ready;
    assign last_beat = (beat_q == WO_W'(LINE_WORDS-1));
    assign touch_en  = (state_q == ST_LOOKUP) && hit;
    assign fill_en   = (state_q == ST_FILL) && beat_go && last_beat;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)
                    state_d = (rq_we && !cfg_wback) ? ST_WTHRU : ST_RESP;
                else if (rq_we && !cfg_walloc)
                    state_d = ST_WTHRU;
                else if (valid_q[rq_idx][victim] && dirty_q[rq_idx][victim])
                    state_d = ST_WBACK;
                else
                    state_d = ST_FILL;
            end
            ST_WBACK:  if (beat_go && last_beat) state_d = ST_FILL;
            ST_FILL:   if (beat_go && last_beat) state_d = ST_LOOKUP;
            ST_WTHRU:  if (beat_go) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready  = 1'b0;
        cpu_done   = 1'b0;
        cpu_rdata  = rdata_q;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        lookup_err = 1'b0;
        unique case (state_q)
            ST_IDLE:   cpu_ready = 1'b1;
            ST_LOOKUP: lookup_err = multi;
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[rq_idx][vic_q], rq_idx, beat_q, {BYTE_W{1'b0}}};
                mem_wdata = data_q[rq_idx][vic_q][beat_q];
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {rq_tag, rq_idx, beat_q, {BYTE_W{1'b0}}};
            end
            ST_WTHRU: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rq_tag, rq_idx, rq_word, {BYTE_W{1'b0}}};
                mem_wdata = rq_wdata;
            end
            ST_RESP:   cpu_done = 1'b1;
            default:   ;
        endcase
    end

    // request capture, status bits and beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_tag   <= '0;
            rq_idx   <= '0;
            rq_word  <= '0;
            rq_wdata <= '0;
            rdata_q  <= '0;
            vic_q    <= '0;
            beat_q   <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req) begin
                    rq_we    <= cpu_we;
                    rq_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
                    rq_idx   <= cpu_addr[BYTE_W+WO_W +: IDX_W];
                    rq_word  <= cpu_addr[BYTE_W +: WO_W];
                    rq_wdata <= cpu_wdata;
                end
                ST_LOOKUP: begin
                    beat_q <= '0;
                    if (hit) begin
                        rdata_q <= data_q[rq_idx][hit_way][rq_word];
                        if (rq_we && cfg_wback) dirty_q[rq_idx][hit_way] <= 1'b1;
                    end else begin
                        vic_q <= victim;
                    end
                end
                ST_WBACK: if (beat_go) beat_q <= beat_q + WO_W'(1);
                ST_FILL: if (beat_go) begin
                    beat_q <= beat_q + WO_W'(1);
                    if (last_beat) begin
                        valid_q[rq_idx][vic_q] <= 1'b1;
                        dirty_q[rq_idx][vic_q] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // line data and tags
    always_ff @(posedge clk) begin
        if (state_q == ST_LOOKUP && hit && rq_we)
            data_q[rq_idx][hit_way][rq_word] <= rq_wdata;
        if (state_q == ST_FILL && beat_go) begin
            data_q[rq_idx][vic_q][beat_q] <= mem_rdata;
            if (last_beat) tag_q[rq_idx][vic_q] <= rq_tag;
        end
    end

    // R12: a beat waits unchanged for the memory to take it
    a_r12_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
    // R13: no new request is taken while memory traffic is active
    a_r13_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cpu_ready);
    // R13: completion lasts a single cycle
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    // R4: fills never leave two valid ways with the same tag
    a_r4_no_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> !lookup_err);
    // R11: a set with an empty way never triggers a writeback
    a_r11_no_wb_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !(&valid_q[rq_idx])) |=> (state_q != ST_WBACK));
endmodule

// File: tb/sim_cache_ctrl.sv
`timescale 1ns/1ps
module sim_cache_ctrl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NWORDS = 1 << (ADDR_W - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wback = 1'b1, cfg_walloc = 1'b1;
    logic [1:0] cfg_repl = 2'd0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done, mem_valid, mem_we, lookup_err;
    logic [DATA_W-1:0] cpu_rdata, mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ready = 1'b1;

    logic [DATA_W-1:0] mem_arr [NWORDS];
    logic [DATA_W-1:0] ref_mem [NWORDS];
    logic [ADDR_W-1:0] rd_log  [8];
    int rd_beats = 0, wr_beats = 0, err_seen = 0, rdy_viol = 0;
    int n_tests = 0, n_fail = 0;
    logic stall_en = 1'b0;

    // last access results
    logic [DATA_W-1:0] l_rdata;
    int l_cyc, l_rd, l_wr, l_rd0;

    always #4 clk = ~clk;

    cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wback(cfg_wback), .cfg_walloc(cfg_walloc),
        .cfg_repl(cfg_repl), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .lookup_err(lookup_err)
    );

    function automatic logic [DATA_W-1:0] init_val(int i);
        return (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    assign mem_rdata = mem_arr[mem_addr[ADDR_W-1:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            if (rd_beats == 0)
                for (int i = 0; i < NWORDS; i++) mem_arr[i] <= init_val(i);
        end else if (mem_valid && mem_ready && mem_we) begin
            mem_arr[mem_addr[ADDR_W-1:2]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                if (mem_we) wr_beats++;
                else begin
                    rd_log[rd_beats % 8] = mem_addr;
                    rd_beats++;
                end
            end
            if (lookup_err) err_seen++;
            if (mem_valid && cpu_ready) rdy_viol++;
        end
    end

    always @(negedge clk)
        mem_ready <= stall_en ? ($urandom % 4 != 0) : 1'b1;

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input bit we, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] wd);
        int r0, w0;
        r0 = rd_beats; w0 = wr_beats;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        l_cyc = 1;
        while (!cpu_done) begin
            l_cyc++;
            @(negedge clk);
        end
        l_rdata = cpu_rdata;
        @(negedge clk);
        l_rd = rd_beats - r0; l_wr = wr_beats - w0; l_rd0 = r0;
        if (we) ref_mem[addr[ADDR_W-1:2]] = wd;
        else check(l_rdata == ref_mem[addr[ADDR_W-1:2]], "R3 read data", l_rdata,
                   ref_mem[addr[ADDR_W-1:2]]);
    endtask

    task automatic check_fill_addrs(input logic [ADDR_W-1:0] addr);
        for (int k = 0; k < 4; k++) begin
            logic [ADDR_W-1:0] e;
            e = {addr[ADDR_W-1:4], 4'h0} + ADDR_W'(4 * k);
            check(rd_log[(l_rd0 + k) % 8] == e, "R1/R12 fill beat address",
                  DATA_W'(rd_log[(l_rd0 + k) % 8]), DATA_W'(e));
        end
    endtask

    localparam logic [ADDR_W-1:0] LA = 12'h000, LB = 12'h040, LC = 12'h080, LD = 12'h0C0;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = init_val(i);
        do_reset();
        // R14 reset state
        check(cpu_ready == 1'b1, "R14 ready after reset", DATA_W'(cpu_ready), 1);
        check(cpu_done == 1'b0, "R14 done after reset", DATA_W'(cpu_done), 0);
        check(mem_valid == 1'b0, "R14 mem idle after reset", DATA_W'(mem_valid), 0);

        // Phase: write-back, allocate, LRU
        cfg_wback = 1'b1; cfg_walloc = 1'b1; cfg_repl = 2'd0;
        access(0, LA, 0);
        check(l_rd == 4, "R14/R2 first read misses, full line", l_rd, 4);
        check(l_wr == 0, "R11 no writeback into empty way", l_wr, 0);
        check_fill_addrs(LA);
        access(0, LA + 12'h4, 0);
        check(l_cyc == 2 && l_rd == 0, "R2 hit latency", l_cyc, 2);
        access(0, LB + 12'h8, 0);
        check(l_rd == 4 && l_wr == 0, "R11 second way filled", l_rd, 4);
        check_fill_addrs(LB + 12'h8);
        access(0, LA, 0);
        check(l_cyc == 2, "R11 first line kept", l_cyc, 2);
        access(1, LC + 12'h8, 32'hC0DE_0001);
        check(l_rd == 4 && l_wr == 0, "R7 allocate fetches line", l_rd, 4);
        check(mem_arr[(LC + 12'h8) >> 2] == init_val((LC + 12'h8) >> 2),
              "R5 write hit leaves memory", mem_arr[(LC + 12'h8) >> 2],
              init_val((LC + 12'h8) >> 2));
        access(0, LA, 0);
        check(l_cyc == 2, "R8 recently used way survived", l_cyc, 2);
        access(0, LB, 0);
        check(l_rd == 4, "R8 least recent way was evicted", l_rd, 4);
        check(l_wr == 4, "R5 dirty victim written back", l_wr, 4);
        check(mem_arr[(LC + 12'h8) >> 2] == 32'hC0DE_0001, "R5 writeback data",
              mem_arr[(LC + 12'h8) >> 2], 32'hC0DE_0001);
        access(0, LC + 12'h8, 0);
        check(l_rd == 4, "R8 evicted line refetched", l_rd, 4);

        // Phase: write-through, write-around, fill order
        do_reset();
        cfg_wback = 1'b0; cfg_walloc = 1'b0; cfg_repl = 2'd1;
        access(0, LA, 0);
        access(0, LB, 0);
        access(0, LA, 0);
        check(l_cyc == 2, "R9 hit before replacement", l_cyc, 2);
        access(0, LC, 0);
        check(l_rd == 4 && l_wr == 0, "R9 clean eviction", l_wr, 0);
        access(0, LB, 0);
        check(l_cyc == 2, "R9 younger fill kept despite hit on older", l_cyc, 2);
        access(0, LA, 0);
        check(l_rd == 4, "R9 oldest fill evicted", l_rd, 4);
        access(1, LC + 12'h4, 32'hBEEF_0002);
        check(l_wr == 1 && l_rd == 0, "R6 write hit sends one beat", l_wr, 1);
        check(mem_arr[(LC + 12'h4) >> 2] == 32'hBEEF_0002, "R6 memory updated",
              mem_arr[(LC + 12'h4) >> 2], 32'hBEEF_0002);
        access(0, LC + 12'h4, 0);
        check(l_cyc == 2, "R6 cache copy updated", l_cyc, 2);
        access(1, LD, 32'hFACE_0003);
        check(l_wr == 1 && l_rd == 0, "R7 write-around, no fetch", l_rd, 0);
        check(mem_arr[LD >> 2] == 32'hFACE_0003, "R7 write-around data",
              mem_arr[LD >> 2], 32'hFACE_0003);
        access(0, LD, 0);
        check(l_rd == 4, "R7 write-around did not allocate", l_rd, 4);

        // Phase: random mix with memory stalls
        do_reset();
        stall_en = 1'b1;
        for (int op = 0; op < 600; op++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            bit w;
            if (op % 50 == 0) begin
                cfg_repl   = 2'($urandom % 3);
                cfg_wback  = 1'($urandom);
                cfg_walloc = 1'($urandom);
            end
            a = {3'b000, 3'($urandom), 2'($urandom), 2'($urandom), 2'b00};
            d = $urandom;
            w = ($urandom % 3 == 0);
            access(w, a, d);
            if (w && !cfg_wback)
                check(mem_arr[a >> 2] == d, "R6 write-through in random mix",
                      mem_arr[a >> 2], d);
            if (!w && cfg_repl == 2'd2)
                check(l_rd == 0 || l_rd == 4, "R10 random mode line transfer", l_rd, 4);
        end
        stall_en = 1'b0;
        check(err_seen == 0, "R4 no multi-way match", err_seen, 0);
        check(rdy_viol == 0, "R13 ready low during transfers", rdy_viol, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule